// File: doc/BRIEF.md
# GPIO Line Interrupt Detector

This block watches the input lines of a small general-purpose port and turns selected activity on them into one interrupt request. Each line is set up on its own: it can react to an edge (rising, falling, or any change) or to a level (high or low). Every detected event sets a bit in a raw status vector. Software clears the edge bits one by one. A mask vector chooses which raw bits may reach the single interrupt output.

The external lines are asynchronous. They go through a two-stage synchronizer before detection. An edge is found by comparing each synchronized line with its value one cycle earlier. The port direction vector comes from the surrounding pin logic. Lines driven as outputs do not produce edge events. Software reaches the block through a plain register port: a write strobe with address and data, and combinational read data for the address presented. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `gpint_top`

## Requirements
- R1: After reset, the sense, both-edge, event and mask registers read 0, the raw status reads 0 and `irq` is low.
- R2: The sense (0x404), both-edge (0x408), event (0x40C) and mask (0x410) registers take `wdata` on a write and read back at the same offsets.
- R3: On an edge-mode line (sense bit 0, both-edge bit 0), event bit 1 sets the raw bit on a rising change and event bit 0 sets it on a falling change. The opposite edge is ignored.
- R4: On an edge-mode line with its both-edge bit at 1, any change of the line sets the raw bit, whatever the event bit.
- R5: On a level-mode line (sense bit 1), event bit 1 sets the raw bit while the line is high and event bit 0 sets it while the line is low. A clear issued while the condition holds leaves the bit set.
- R6: A write to 0x41C clears each raw bit whose `wdata` bit is 1 and leaves the other bits alone. An edge-set bit stays at 1 after the line returns, until it is cleared.
- R7: Edge events are taken only from lines whose `dir` bit is 0 (input). Changes on a line with `dir` bit 1 do not set its raw bit.
- R8: The raw status reads at 0x414, and the masked status reads at 0x418 as raw AND mask.
- R9: `irq` is high exactly when at least one bit of raw AND mask is 1.
- R10: A change on `pins` driven between clock edges becomes visible in the raw status and on `irq` after the third following rising edge, and not before.
- R11: Writes to 0x414, 0x418 or any unmapped offset change no register. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| pins | input | N_LINES | Asynchronous external line values |
| dir | input | N_LINES | Line direction, 1 = output, 0 = input |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | N_LINES | Register write data |
| rdata | output | N_LINES | Read data for `addr`, combinational |
| irq | output | 1 | Combined masked interrupt request |

## Verification
A line change takes three rising edges to reach the raw status and `irq`: two synchronizer stages, then the status register. The previous-value register supplies the comparison during the third edge. A register write takes effect at the edge where the strobe is sampled. A level condition that already holds sets its raw bit one edge after the configuration that enables it. The bench drives inputs on falling edges. It waits at least three rising edges before it reads a result, and it reads `rdata` one time step after presenting the address. The timing test samples just after the second edge and again just after the third, so that an off-by-one in the path shows up.

// File: rtl/gpint_pkg.sv
package gpint_pkg;

  localparam int OFS_W = 12;

  localparam logic [OFS_W-1:0] OFS_SENSE = 12'h404;
  localparam logic [OFS_W-1:0] OFS_BOTH  = 12'h408;
  localparam logic [OFS_W-1:0] OFS_EVENT = 12'h40C;
  localparam logic [OFS_W-1:0] OFS_MASK  = 12'h410;
  localparam logic [OFS_W-1:0] OFS_RAW   = 12'h414;
  localparam logic [OFS_W-1:0] OFS_MSKD  = 12'h418;
  localparam logic [OFS_W-1:0] OFS_CLEAR = 12'h41C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SENSE,
    SEL_BOTH,
    SEL_EVENT,
    SEL_MASK,
    SEL_RAW,
    SEL_MSKD,
    SEL_CLEAR
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
    reg_sel_e s;
    case (ofs)
      OFS_SENSE: s = SEL_SENSE;
      OFS_BOTH:  s = SEL_BOTH;
      OFS_EVENT: s = SEL_EVENT;
      OFS_MASK:  s = SEL_MASK;
      OFS_RAW:   s = SEL_RAW;
      OFS_MSKD:  s = SEL_MSKD;
      OFS_CLEAR: s = SEL_CLEAR;
      default:   s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gpint_sync.sv
module gpint_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign stg_d[s] = d;
      end else begin : g_next
        assign stg_d[s] = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_d[s];
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpint_cfg.sv
module gpint_cfg
  import gpint_pkg::*;
#(
  parameter int N      = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  input  logic [N-1:0]      raw_i,
  output logic [N-1:0]      sense_o,
  output logic [N-1:0]      both_o,
  output logic [N-1:0]      event_o,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      clr_o,
  output logic [N-1:0]      rdata
);
  reg_sel_e     sel;
  logic         ld_sense, ld_both, ld_event, ld_mask;
  logic [N-1:0] sense_q, both_q, event_q, mask_q;
  logic [N-1:0] sense_d, both_d, event_d, mask_d;

  assign sel = decode_ofs(OFS_W'(addr));

  always_comb begin
    ld_sense = wr_en && (sel == SEL_SENSE);
    ld_both  = wr_en && (sel == SEL_BOTH);
    ld_event = wr_en && (sel == SEL_EVENT);
    ld_mask  = wr_en && (sel == SEL_MASK);
    sense_d  = ld_sense ? wdata : sense_q;
    both_d   = ld_both  ? wdata : both_q;
    event_d  = ld_event ? wdata : event_q;
    mask_d   = ld_mask  ? wdata : mask_q;
    clr_o    = (wr_en && (sel == SEL_CLEAR)) ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      both_q  <= '0;
      event_q <= '0;
      mask_q  <= '0;
    end else begin
      sense_q <= sense_d;
      both_q  <= both_d;
      event_q <= event_d;
      mask_q  <= mask_d;
    end
  end

  always_comb begin
    case (sel)
      SEL_SENSE: rdata = sense_q;
      SEL_BOTH:  rdata = both_q;
      SEL_EVENT: rdata = event_q;
      SEL_MASK:  rdata = mask_q;
      SEL_RAW:   rdata = raw_i;
      SEL_MSKD:  rdata = raw_i & mask_q;
      default:   rdata = '0;
    endcase
  end

  assign sense_o = sense_q;
  assign both_o  = both_q;
  assign event_o = event_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/gpint_detect.sv
module gpint_detect #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] smp,
  input  logic [N-1:0] dir,
  input  logic [N-1:0] sense,
  input  logic [N-1:0] both,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] raw
);
  logic [N-1:0] prev_q;
  logic [N-1:0] raw_q, raw_d;
  logic [N-1:0] hit;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_line
      logic rise, fall, edge_hit, lvl_hit;
      always_comb begin
        rise     = smp[i] & ~prev_q[i];
        fall     = ~smp[i] & prev_q[i];
        edge_hit = ~dir[i] & ~sense[i] &
                   (both[i] ? (rise | fall) : (evt[i] ? rise : fall));
        lvl_hit  = sense[i] & (smp[i] == evt[i]);
        hit[i]   = edge_hit | lvl_hit;
      end
    end
  endgenerate

  always_comb raw_d = (raw_q & ~clr) | hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      raw_q  <= '0;
    end else begin
      prev_q <= smp;
      raw_q  <= raw_d;
    end
  end

  assign raw = raw_q;
endmodule

// File: rtl/gpint_top.sv
module gpint_top #(
  parameter int N_LINES     = 8,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] pins,
  input  logic [N_LINES-1:0] dir,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [N_LINES-1:0] wdata,
  output logic [N_LINES-1:0] rdata,
  output logic               irq
);
  logic [1:0]         rst_pipe_q;
  logic               rst_int_n;
  logic [N_LINES-1:0] smp, sense, both, evt, mask, clr, raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  gpint_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d(pins), .q(smp)
  );

  gpint_cfg #(.N(N_LINES), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .raw_i(raw), .sense_o(sense), .both_o(both),
    .event_o(evt), .mask_o(mask), .clr_o(clr), .rdata(rdata)
  );

  gpint_detect #(.N(N_LINES)) u_det (
    .clk(clk), .rst_n(rst_int_n), .smp(smp), .dir(dir), .sense(sense),
    .both(both), .evt(evt), .clr(clr), .raw(raw)
  );

  assign irq = |(raw & mask);
endmodule

// File: rtl/gpint_chk.sv
module gpint_chk
  import gpint_pkg::*;
#(
  parameter int N      = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [N-1:0]      wdata,
  input logic [N-1:0]      smp,
  input logic [N-1:0]      dir,
  input logic [N-1:0]      sense,
  input logic [N-1:0]      evt,
  input logic [N-1:0]      mask,
  input logic [N-1:0]      raw,
  input logic              irq
);
  logic [N-1:0] clr_seen, lvl_live, edge_only;
  logic         wr_sense;

  always_comb begin
    clr_seen  = (wr_en && (OFS_W'(addr) == OFS_CLEAR)) ? wdata : '0;
    lvl_live  = sense & ~(smp ^ evt);
    edge_only = dir & ~sense;
    wr_sense  = wr_en && (OFS_W'(addr) == OFS_SENSE);
  end

  // R9: no mask bit, no request
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);

  // R6: a raw bit only drops after a clear write covering it
  assert_clear_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(raw) & ~raw) & ~$past(clr_seen)) == '0));

  // R5: a live level condition has its raw bit set on the next cycle
  assert_level_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(lvl_live) & ~raw) == '0));

  // R7: output lines in edge mode never raise their raw bit
  assert_out_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~$past(raw) & raw & $past(edge_only)) == '0));

  // R2: sense register takes the written value
  assert_sense_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sense |=> (sense == $past(wdata)));
endmodule

bind gpint_top gpint_chk #(.N(N_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .smp(smp), .dir(dir), .sense(sense), .evt(evt), .mask(mask), .raw(raw),
  .irq(irq)
);

// File: tb/sim_gpint_top.sv
`timescale 1ns/100ps
module sim_gpint_top;
  localparam int N  = 8;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  pins, dir, wdata, rdata;
  logic          wr_en, irq;
  logic [AW-1:0] addr;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  gpint_top u0 (.clk(clk), .rst_n(rst_n), .pins(pins), .dir(dir),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2.5 clk = ~clk;

  // sense, both, event, before, after, expected raw
  localparam int NV = 5;
  localparam logic [47:0] VEC [NV] = '{
    {8'h00, 8'h00, 8'hFF, 8'h00, 8'h0F, 8'h0F},
    {8'h00, 8'h00, 8'h00, 8'hFF, 8'hF0, 8'h0F},
    {8'h00, 8'hFF, 8'h00, 8'hAA, 8'h55, 8'hFF},
    {8'hFF, 8'h00, 8'hF0, 8'h00, 8'h3C, 8'h3F},
    {8'h0F, 8'h30, 8'h55, 8'h00, 8'hC6, 8'h4E}
  };

  task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [N-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    rst_n = 1'b0; pins = '0; dir = '0; wr_en = 1'b0; addr = '0; wdata = '0;
    settle(3);
    rst_n = 1'b1;
    settle(4);

    // R1 reset values
    rd(12'h404, v); chk("R1 sense", v, 8'h00);
    rd(12'h408, v); chk("R1 both", v, 8'h00);
    rd(12'h40C, v); chk("R1 event", v, 8'h00);
    rd(12'h410, v); chk("R1 mask", v, 8'h00);
    rd(12'h414, v); chk("R1 raw", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // R2 readback
    wr(12'h410, 8'hA5); rd(12'h410, v); chk("R2 mask", v, 8'hA5);
    wr(12'h408, 8'h5A); rd(12'h408, v); chk("R2 both", v, 8'h5A);

    // table: R3 R4 R5 and mixed modes, checked also through R8 and R9
    wr(12'h410, 8'hFF);
    for (int k = 0; k < NV; k++) begin
      logic [47:0] e;
      e = VEC[k];
      wr(12'h404, e[47:40]);
      wr(12'h408, e[39:32]);
      wr(12'h40C, e[31:24]);
      pins = e[23:16];
      settle(5);
      wr(12'h41C, 8'hFF);
      pins = e[15:8];
      settle(4);
      rd(12'h414, v); chk($sformatf("R3/R4/R5 row %0d raw", k), v, e[7:0]);
      rd(12'h418, v); chk($sformatf("R8 row %0d masked", k), v, e[7:0]);
      chk($sformatf("R9 row %0d irq", k), {7'd0, irq}, {7'd0, |e[7:0]});
    end

    // R7 output lines produce no edge events
    wr(12'h404, 8'h00); wr(12'h408, 8'hFF); dir = 8'hFF;
    settle(4); wr(12'h41C, 8'hFF);
    pins = ~pins; settle(5);
    rd(12'h414, v); chk("R7 output lines", v, 8'h00);
    dir = 8'h00;

    // R6 edge latch and selective clear
    pins = 8'h00; wr(12'h408, 8'h00); wr(12'h40C, 8'h03);
    settle(5); wr(12'h41C, 8'hFF);
    pins = 8'h03; settle(4); pins = 8'h00; settle(4);
    rd(12'h414, v); chk("R6 latched after return", v, 8'h03);
    wr(12'h41C, 8'h02); rd(12'h414, v); chk("R6 selective clear", v, 8'h01);

    // R8 R9 masking
    wr(12'h410, 8'h02); rd(12'h418, v); chk("R8 masked off", v, 8'h00);
    chk("R9 irq low", {7'd0, irq}, 8'h00);
    wr(12'h410, 8'h01); rd(12'h418, v); chk("R8 masked on", v, 8'h01);
    chk("R9 irq high", {7'd0, irq}, 8'h01);
    wr(12'h41C, 8'hFF);

    // R5 level re-set after clear
    wr(12'h404, 8'h01); wr(12'h40C, 8'h01);
    pins = 8'h01; settle(4);
    wr(12'h41C, 8'h01); rd(12'h414, v); chk("R5 held level re-sets", v, 8'h01);
    pins = 8'h00; settle(4);
    wr(12'h41C, 8'h01); rd(12'h414, v); chk("R5 released level clears", v, 8'h00);

    // R10 latency: rising edge on line 1
    wr(12'h404, 8'h00); wr(12'h40C, 8'h02);
    @(negedge clk); pins = 8'h02;
    @(posedge clk); @(posedge clk); #1;
    rd(12'h414, v); chk("R10 not after two edges", v, 8'h00);
    @(posedge clk); #1;
    rd(12'h414, v); chk("R10 set after third edge", v, 8'h02);

    // R11 read-only and unmapped offsets
    wr(12'h414, 8'h00); wr(12'h418, 8'h00); wr(12'h500, 8'hFF);
    rd(12'h414, v); chk("R11 raw unchanged", v, 8'h02);
    rd(12'h40C, v); chk("R11 event unchanged", v, 8'h02);
    rd(12'h500, v); chk("R11 unmapped read", v, 8'h00);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule